// File: doc/BRIEF.md
# Interrupt Status, Mask and Enable Unit

This unit gathers single-cycle event strobes from a serial storage host controller and turns them into one level-sensitive interrupt line for the processor. Each event source owns one bit in a sticky status register. A bit stays set until software acknowledges it. A mask register with one bit per source decides which pending bits may reach the line. A separate top-level enable then gates the combined result.

Software acknowledges pending events by writing zero to the status bits it has handled. Writing one to a status bit leaves that bit as it is, so a handler can clear exactly the bits it serviced without racing newer events. A typical run masks everything at start-up and clears all status. It then opens only the command-completion source and the link-error source, and finally sets the top-level enable. The interrupt line comes from a flop, so it follows the register state one clock later.

Registers are reached through a small word-addressed port. Address 0 is status, 1 is mask, 2 is the top-level enable, and 3 is unused. Writes take effect on the clock edge where the write strobe is high. Reads are combinational from the address.

Top module: `intr_stat_mask_unit`

## Requirements
- R1: After reset, status reads 0x000, mask reads 0x7FF (every source blocked), the enable register reads 0 and `irq_o` is low.
- R2: A high bit on `evt_i` sets the matching status bit at the next clock edge. The bit stays set whatever the mask or enable hold. Bit 0 is the command/DMA completion event and bit 3 is the link-error event. Mask bits 1 and 2 belong to the critical-error and error sources.
- R3: A write to address 0 clears each status bit whose write-data bit is 0 and keeps each bit whose write-data bit is 1. Writing all zeros clears every status bit.
- R4: When an event and a clearing write hit the same status bit in the same cycle, the bit ends up set. Other bits cleared by that write still clear.
- R5: A mask bit of 1 blocks its source. `irq_o` is high exactly when, on the previous clock edge, some status bit was set with its mask bit at 0 and the enable bit was 1.
- R6: The enable register holds a single bit at data bit 11, and all other read bits are 0. With that bit at 0, `irq_o` stays low.
- R7: Status and mask are 11 bits wide. Data bits 31..11 are ignored on write and read back as 0, so writing 0xFFFFFFFF to mask reads back 0x7FF.
- R8: Unmasking an already pending bit (with enable on) raises `irq_o` one cycle after the edge that writes the mask. Clearing the last unmasked pending bit drops it one cycle after the edge that clears it.
- R9: Address 3 reads as 0, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| evt_i | input | 11 | Event strobes, one per source |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| irq_o | output | 1 | Registered level interrupt to the processor |

## Verification
The case that needs care is a new event arriving in the same cycle as software's acknowledge write to the status register. The bench provokes it for every source. It first leaves a neighbouring bit pending, then drives the event strobe and an all-zero status write in the same cycle. The result is judged by reading status back: the colliding bit must stay set and the neighbour must be gone.

// File: rtl/isu_pkg.sv
package isu_pkg;
  localparam int ISU_ADDR_W = 2;

  typedef enum logic [ISU_ADDR_W-1:0] {
    ISU_STATUS = 2'd0,
    ISU_MASK   = 2'd1,
    ISU_ENABLE = 2'd2,
    ISU_SPARE  = 2'd3
  } isu_addr_e;
endpackage

// File: rtl/isu_rst_sync.sv
module isu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/isu_status_bank.sv
module isu_status_bank #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic               ack_we_i,
  input  logic [NUM_SRC-1:0] ack_keep_i,
  output logic [NUM_SRC-1:0] sts_o
);
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    logic bit_q;
    logic bit_d;
    logic bit_ce;

    // An event overrides an acknowledge in the same cycle.
    always_comb begin
      bit_d = bit_q;
      if (ack_we_i && !ack_keep_i[b]) bit_d = 1'b0;
      if (evt_i[b])                   bit_d = 1'b1;
    end

    assign bit_ce = evt_i[b] | ack_we_i;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bit_q <= 1'b0;
      else if (bit_ce) bit_q <= bit_d;
    end

    assign sts_o[b] = bit_q;
  end
endmodule

// File: rtl/isu_ctrl_regs.sv
module isu_ctrl_regs #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               mask_we_i,
  input  logic [NUM_SRC-1:0] mask_wdata_i,
  input  logic               en_we_i,
  input  logic               en_wdata_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               en_o
);
  localparam logic [NUM_SRC-1:0] MASK_ALL = {NUM_SRC{1'b1}};

  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic               en_q, en_d;

  always_comb begin
    mask_d = mask_wdata_i;
    en_d   = en_wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_q <= MASK_ALL;
    else if (mask_we_i) mask_q <= mask_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       en_q <= 1'b0;
    else if (en_we_i) en_q <= en_d;
  end

  assign mask_o = mask_q;
  assign en_o   = en_q;
endmodule

// File: rtl/isu_irq_drive.sv
module isu_irq_drive #(
  parameter int NUM_SRC = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] sts_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               en_i,
  output logic               irq_o
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = (|(sts_i & ~mask_i)) & en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/intr_stat_mask_unit.sv
module intr_stat_mask_unit
  import isu_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32,
  parameter int EN_BIT  = 11
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_SRC-1:0]    evt_i,
  input  logic                  reg_we_i,
  input  logic [ISU_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic                  irq_o
);
  localparam int PAD_W = DATA_W - NUM_SRC;

  logic               rst_sync_n;
  logic               sts_we, mask_we, en_we;
  logic [NUM_SRC-1:0] sts_q;
  logic [NUM_SRC-1:0] mask_q;
  logic               en_q;

  isu_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    sts_we  = reg_we_i && (reg_addr_i == ISU_STATUS);
    mask_we = reg_we_i && (reg_addr_i == ISU_MASK);
    en_we   = reg_we_i && (reg_addr_i == ISU_ENABLE);
  end

  isu_status_bank #(.NUM_SRC(NUM_SRC)) i_status (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .evt_i      (evt_i),
    .ack_we_i   (sts_we),
    .ack_keep_i (reg_wdata_i[NUM_SRC-1:0]),
    .sts_o      (sts_q)
  );

  isu_ctrl_regs #(.NUM_SRC(NUM_SRC)) i_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .mask_we_i    (mask_we),
    .mask_wdata_i (reg_wdata_i[NUM_SRC-1:0]),
    .en_we_i      (en_we),
    .en_wdata_i   (reg_wdata_i[EN_BIT]),
    .mask_o       (mask_q),
    .en_o         (en_q)
  );

  isu_irq_drive #(.NUM_SRC(NUM_SRC)) i_irq (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sts_i  (sts_q),
    .mask_i (mask_q),
    .en_i   (en_q),
    .irq_o  (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ISU_STATUS: reg_rdata_o = {{PAD_W{1'b0}}, sts_q};
      ISU_MASK:   reg_rdata_o = {{PAD_W{1'b0}}, mask_q};
      ISU_ENABLE: reg_rdata_o[EN_BIT] = en_q;
      default:    reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/isu_checker.sv
module isu_checker
  import isu_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32
) (
  input logic                  clk,
  input logic                  rst_sync_n,
  input logic [NUM_SRC-1:0]    evt_i,
  input logic                  reg_we_i,
  input logic [ISU_ADDR_W-1:0] reg_addr_i,
  input logic [DATA_W-1:0]     reg_rdata_o,
  input logic [NUM_SRC-1:0]    sts_q,
  input logic [NUM_SRC-1:0]    mask_q,
  input logic                  en_q,
  input logic                  irq_o
);
  // R2: with no status write, no pending bit may fall
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(reg_we_i && reg_addr_i == ISU_STATUS) |=> ((sts_q & $past(sts_q)) == $past(sts_q)));

  // R3: a bit cannot rise without its event
  a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_i)) == '0));

  // R4: every strobed event is pending afterwards, even against a clearing write
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|evt_i) |=> ((sts_q & $past(evt_i)) == $past(evt_i)));

  // R5: line follows unmasked pending state of the previous edge
  a_r5_irq_follows: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_o == ($past(|(sts_q & ~mask_q)) && $past(en_q))));

  // R6: enable off keeps the line low on the next cycle
  a_r6_enable_gate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_q |=> !irq_o);

  // R7: upper read bits are zero on status and mask
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i != ISU_ENABLE) |-> (reg_rdata_o[DATA_W-1:NUM_SRC] == '0));

  // R9: spare address reads zero
  a_r9_spare_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr_i == ISU_SPARE) |-> (reg_rdata_o == '0));
endmodule

bind intr_stat_mask_unit isu_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) i_isu_checker (
  .clk         (clk),
  .rst_sync_n  (rst_sync_n),
  .evt_i       (evt_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_rdata_o (reg_rdata_o),
  .sts_q       (sts_q),
  .mask_q      (mask_q),
  .en_q        (en_q),
  .irq_o       (irq_o)
);

// File: tb/test_intr_stat_mask_unit.sv
`timescale 1ns/1ps
module test_intr_stat_mask_unit;
  localparam int NS = 11;
  localparam logic [31:0] ALL = 32'h7FF;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] evt;
  logic        we;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intr_stat_mask_unit i_intr_stat_mask_unit (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    chk(req, rdata, exp);
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt = v;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; evt = '0; we = 1'b0; addr = 2'd0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd("R1 status", 2'd0, 32'h0);
    rd("R1 mask", 2'd1, ALL);
    rd("R1 enable", 2'd2, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R6 enable bit only at position 11
    wr(2'd2, 32'hFFFF_FFFF);
    rd("R6 enable readback", 2'd2, 32'h800);

    // R7 mask upper bits dropped
    wr(2'd1, 32'hFFFF_FFFF);
    rd("R7 mask upper zero", 2'd1, ALL);

    // Per-source sweep: R2, R5, R8, R3
    for (int i = 0; i < NS; i++) begin
      logic [31:0] b;
      b = 32'h1 << i;
      pulse(b[10:0]);
      rd("R2 sticky set while masked", 2'd0, b);
      tick();
      chk("R5 masked source blocked", {31'b0, irq}, 32'h0);
      wr(2'd1, ALL & ~b);
      chk("R8 irq still low at mask edge", {31'b0, irq}, 32'h0);
      tick();
      chk("R8 irq high after unmask", {31'b0, irq}, 32'h1);
      wr(2'd0, ALL);
      rd("R3 write one keeps", 2'd0, b);
      wr(2'd0, ~b);
      rd("R3 write zero clears", 2'd0, 32'h0);
      tick();
      chk("R8 irq drops after clear", {31'b0, irq}, 32'h0);
      wr(2'd1, ALL);
    end

    // R3 selective keep, then clear-all
    pulse(11'h7FF);
    rd("R7 status all set upper zero", 2'd0, ALL);
    wr(2'd0, 32'hFFFF_F555);
    rd("R3 selective clear", 2'd0, 32'h555);
    wr(2'd0, 32'h0);
    rd("R3 clear all", 2'd0, 32'h0);

    // R4 event versus clearing write in the same cycle
    for (int i = 0; i < NS; i++) begin
      int j;
      j = (i + 1) % NS;
      pulse(11'(1 << j));
      @(negedge clk);
      evt = 11'(1 << i); we = 1'b1; addr = 2'd0; wdata = 32'h0;
      @(negedge clk);
      evt = '0; we = 1'b0;
      rd("R4 event wins over clear", 2'd0, 32'h1 << i);
      wr(2'd0, 32'h0);
    end

    // R6 enable gating with a pending unmasked source (bits 0 and 3 open)
    wr(2'd1, ALL & ~32'h9);
    pulse(11'h008);
    tick();
    chk("R6 irq with enable on", {31'b0, irq}, 32'h1);
    wr(2'd2, 32'hFFFF_F7FF);
    rd("R6 enable off readback", 2'd2, 32'h0);
    tick();
    chk("R6 irq off when disabled", {31'b0, irq}, 32'h0);
    rd("R2 status kept while disabled", 2'd0, 32'h8);
    wr(2'd2, 32'h800);
    tick();
    chk("R6 irq back on", {31'b0, irq}, 32'h1);
    pulse(11'h004);
    rd("R5 masked source still latches", 2'd0, 32'hC);

    // R9 spare address
    wr(2'd3, 32'h0);
    rd("R9 spare reads zero", 2'd3, 32'h0);
    rd("R9 status untouched", 2'd0, 32'hC);
    rd("R9 mask untouched", 2'd1, ALL & ~32'h9);
    rd("R9 enable untouched", 2'd2, 32'h800);
    chk("R9 irq untouched", {31'b0, irq}, 32'h1);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule